// File: doc/BRIEF.md
# Leading-Edge Pulse Time Extractor

This block takes one stream of baseline-corrected photomultiplier samples, one sample per clock, and reports when a pulse arrived with sub-sample resolution. A candidate pulse is qualified only after two back-to-back samples rise strictly above a programmable level. While qualified, the block watches the slope between neighbouring samples. The first point where a rising difference turns flat or negative marks the top of the pulse.

The crossing point of the difference signal is interpolated linearly between the last rising step and the first non-rising one. This gives a fraction of a sample period. The integer part comes from a free-running tick counter. A fixed back-off of twelve sample periods is then removed, so that the stamp refers to the leading edge and not to the maximum. Each result appears as a one-cycle strobe, together with the stamp and the height of the top sample.

A candidate that sinks below the level before its top is found is dropped without any output. After a result, the block ignores the stream until a sample falls back to or below the level. This keeps a ringing or double-humped pulse from producing two results.

Top module: `pulse_time_extractor`

## Requirements
- R1: While reset is asserted and after its release, `time_valid`, `time_stamp` and `peak_amp` are all zero until the first result.
- R2: A sample counts as above the level only when it is strictly greater than `threshold`; no result is produced unless the two samples forming the top (index n-1 and n) are both above the level, so an isolated spike or a pulse that only reaches the level exactly gives nothing.
- R3: Let s(n) be the sample at index n (index 0 is the first sample after reset release) and d(n) = s(n) - s(n-1), with s(-1) = 0. A result is produced at the first index n where d(n-1) > 0, d(n) <= 0 and both s(n-1) and s(n) are above the level; a flat step (d(n) = 0) counts as the top.
- R4: For a top found at sample index n, `time_valid` is high for exactly the clock that follows the cycle in which s(n) is on `sample_in`, and for no other clock.
- R5: With the strobe, `peak_amp` equals s(n-1).
- R6: The fraction is min(15, floor(16 * d(n-1) / (d(n-1) - d(n)))), an unsigned 4-bit value.
- R7: `time_stamp` holds the integer part in bits [19:4] and the fraction in bits [3:0]; the integer part is (n - 1 - 12) modulo 2^16, so it wraps for tops found within the first twelve samples.
- R8: If a qualified candidate is followed by a sample at or below the level before its top is found, it is dropped with no strobe, and a new result needs two fresh samples above the level.
- R9: After a result, no further result is produced until a sample at or below the level has been seen, even if the signal forms a second maximum while still above the level.
- R10: Between strobes, `time_stamp` and `peak_amp` keep the values of the last result.
- R11: A top that falls on the very sample which completes qualification (the second sample above the level) is reported like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one sample per rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_in | input | 10 | Baseline-corrected unsigned sample |
| threshold | input | 10 | Qualification level; samples must exceed it |
| time_valid | output | 1 | One-cycle strobe for a new result |
| time_stamp | output | 20 | Integer ticks in bits [19:4], fraction in bits [3:0] |
| peak_amp | output | 10 | Sample value at the pulse top |

## Verification
The case that is hardest to reach from the ports is a second maximum that forms while the signal never drops to the level after a first result. Random pulses almost never produce it, because they return to the baseline. The stimulus therefore includes a hand-built double hump that stays above the level between its peaks. It also includes a top that coincides with the qualifying sample, an exact-level plateau, and a top found in the first samples after reset so that the integer part wraps. Randomised triangular pulses with varying levels then go through a reference model. The model derives every expected stamp from the sample indices.

// File: rtl/pte_pkg.sv
package pte_pkg;

    typedef enum logic [1:0] {
        PTE_IDLE  = 2'd0,
        PTE_ARMED = 2'd1,
        PTE_HOLD  = 2'd2
    } pte_state_e;

endpackage

// File: rtl/pte_tick_counter.sv
module pte_tick_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] tick
);

    logic [CNT_W-1:0] tick_d;
    logic [CNT_W-1:0] tick_q;

    always_comb begin
        tick_d = tick_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_d;
        end
    end

    assign tick = tick_q;

endmodule

// File: rtl/pte_history.sv
module pte_history #(
    parameter  int SMP_W  = 10,
    localparam int DIFF_W = SMP_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SMP_W-1:0]  sample_in,
    input  logic [SMP_W-1:0]  threshold,
    output logic [DIFF_W-1:0] cur_diff,
    output logic              cur_above,
    output logic [DIFF_W-1:0] prev_diff,
    output logic              prev_above,
    output logic [SMP_W-1:0]  prev_sample
);

    typedef struct packed {
        logic [SMP_W-1:0]  sample;
        logic [DIFF_W-1:0] diff;
        logic              above;
    } hist_t;

    hist_t hist_d;
    hist_t hist_q;

    always_comb begin
        cur_diff     = {1'b0, sample_in} - {1'b0, hist_q.sample};
        cur_above    = (sample_in > threshold);
        hist_d       = hist_q;
        hist_d.sample = sample_in;
        hist_d.diff   = cur_diff;
        hist_d.above  = cur_above;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    assign prev_diff   = hist_q.diff;
    assign prev_above  = hist_q.above;
    assign prev_sample = hist_q.sample;

endmodule

// File: rtl/pte_interp.sv
module pte_interp #(
    parameter  int SMP_W  = 10,
    parameter  int FRAC_W = 4,
    localparam int DIFF_W = SMP_W + 1,
    localparam int REM_W  = DIFF_W + 1
) (
    input  logic [DIFF_W-1:0] rise_diff,
    input  logic [DIFF_W-1:0] fall_diff,
    output logic [FRAC_W-1:0] frac
);

    // Restoring long division of rise / (rise - fall), one quotient bit
    // per stage; the quotient never exceeds all-ones because rise <= span.
    always_comb begin
        logic [REM_W-1:0] span;
        logic [REM_W-1:0] rem;
        span = {rise_diff[DIFF_W-1], rise_diff} - {fall_diff[DIFF_W-1], fall_diff};
        rem  = {1'b0, rise_diff};
        frac = '0;
        for (int i = FRAC_W - 1; i >= 0; i--) begin
            rem = {rem[REM_W-2:0], 1'b0};
            if (rem >= span) begin
                frac[i] = 1'b1;
                rem     = rem - span;
            end
        end
    end

endmodule

// File: rtl/pulse_time_extractor.sv
module pulse_time_extractor
    import pte_pkg::*;
#(
    parameter  int SMP_W   = 10,
    parameter  int CNT_W   = 16,
    parameter  int FRAC_W  = 4,
    parameter  int BACKOFF = 12,
    localparam int DIFF_W  = SMP_W + 1,
    localparam int TS_W    = CNT_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SMP_W-1:0]  sample_in,
    input  logic [SMP_W-1:0]  threshold,
    output logic              time_valid,
    output logic [TS_W-1:0]   time_stamp,
    output logic [SMP_W-1:0]  peak_amp
);

    // The top sits one sample before the one that reveals it.
    localparam logic [CNT_W-1:0] STAMP_OFS = CNT_W'(BACKOFF + 1);

    typedef struct packed {
        pte_state_e         state;
        logic               valid;
        logic [TS_W-1:0]    stamp;
        logic [SMP_W-1:0]   peak;
    } ctrl_t;

    ctrl_t ctrl_d;
    ctrl_t ctrl_q;

    logic [CNT_W-1:0]  tick;
    logic [DIFF_W-1:0] cur_diff;
    logic [DIFF_W-1:0] prev_diff;
    logic              cur_above;
    logic              prev_above;
    logic [SMP_W-1:0]  prev_sample;
    logic [FRAC_W-1:0] frac;
    logic              rising_before;
    logic              not_rising_now;
    logic              top_hit;

    pte_tick_counter #(
        .CNT_W (CNT_W)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    pte_history #(
        .SMP_W (SMP_W)
    ) u_hist (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_in   (sample_in),
        .threshold   (threshold),
        .cur_diff    (cur_diff),
        .cur_above   (cur_above),
        .prev_diff   (prev_diff),
        .prev_above  (prev_above),
        .prev_sample (prev_sample)
    );

    pte_interp #(
        .SMP_W  (SMP_W),
        .FRAC_W (FRAC_W)
    ) u_interp (
        .rise_diff (prev_diff),
        .fall_diff (cur_diff),
        .frac      (frac)
    );

    always_comb begin
        rising_before  = !prev_diff[DIFF_W-1] && (prev_diff != '0);
        not_rising_now = cur_diff[DIFF_W-1] || (cur_diff == '0);
        top_hit        = cur_above && prev_above && rising_before && not_rising_now;

        ctrl_d       = ctrl_q;
        ctrl_d.valid = 1'b0;

        unique case (ctrl_q.state)
            PTE_IDLE, PTE_ARMED: begin
                if (!cur_above) begin
                    ctrl_d.state = PTE_IDLE;
                end else if (top_hit) begin
                    ctrl_d.state = PTE_HOLD;
                    ctrl_d.valid = 1'b1;
                    ctrl_d.stamp = {tick - STAMP_OFS, frac};
                    ctrl_d.peak  = prev_sample;
                end else if (prev_above) begin
                    ctrl_d.state = PTE_ARMED;
                end
            end
            PTE_HOLD: begin
                if (!cur_above) begin
                    ctrl_d.state = PTE_IDLE;
                end
            end
            default: begin
                ctrl_d.state = PTE_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{state: PTE_IDLE, valid: 1'b0, stamp: '0, peak: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign time_valid = ctrl_q.valid;
    assign time_stamp = ctrl_q.stamp;
    assign peak_amp   = ctrl_q.peak;

endmodule

// File: rtl/pte_checker.sv
module pte_checker #(
    parameter int SMP_W = 10,
    parameter int TS_W  = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SMP_W-1:0] sample_in,
    input logic [SMP_W-1:0] threshold,
    input logic             time_valid,
    input logic [TS_W-1:0]  time_stamp,
    input logic [SMP_W-1:0] peak_amp
);

    p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        time_valid |=> !time_valid);

    p_two_above_r2: assert property (@(posedge clk) disable iff (!rst_n)
        time_valid |-> (($past(sample_in) > $past(threshold)) &&
                        ($past(sample_in, 2) > $past(threshold, 2))));

    p_top_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
        time_valid |-> ($past(sample_in) <= $past(sample_in, 2)));

    p_peak_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
        time_valid |-> (peak_amp == $past(sample_in, 2)));

    p_hold_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !time_valid |-> ($stable(time_stamp) && $stable(peak_amp)));

endmodule

bind pulse_time_extractor pte_checker #(
    .SMP_W (SMP_W),
    .TS_W  (TS_W)
) u_pte_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_in  (sample_in),
    .threshold  (threshold),
    .time_valid (time_valid),
    .time_stamp (time_stamp),
    .peak_amp   (peak_amp)
);

// File: tb/sim_pulse_time_extractor.sv
`timescale 1ns/1ps
module sim_pulse_time_extractor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  sample_in = '0;
    logic [9:0]  threshold = 10'd100;
    logic        time_valid;
    logic [19:0] time_stamp;
    logic [9:0]  peak_amp;

    always #2.5 clk = ~clk;

    pulse_time_extractor u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_in  (sample_in),
        .threshold  (threshold),
        .time_valid (time_valid),
        .time_stamp (time_stamp),
        .peak_amp   (peak_amp)
    );

    typedef struct {
        int          due;
        logic [19:0] ts;
        logic [9:0]  pk;
        string       tag;
    } exp_t;

    exp_t  sb_q[$];
    int    n_checks = 0;
    int    n_fail = 0;
    int    idx = 0;
    bit    run_mon = 0;
    bit    done = 0;
    string cur_tag = "R3";

    // reference state, derived from the requirements
    logic [9:0] m_prev = '0;
    int         m_dprev = 0;
    bit         m_prev_ab = 0;
    bit         m_hold = 0;

    logic [19:0] last_ts = '0;
    logic [9:0]  last_pk = '0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    // Driver: entered at a falling edge, presents one sample, predicts.
    task automatic drive(input int v);
        logic [9:0]  s;
        bit          ab;
        int          d;
        int          fr;
        logic [15:0] ip;
        exp_t        e;
        s = 10'(v);
        sample_in = s;
        ab = (s > threshold);
        d = int'(s) - int'(m_prev);
        if (m_hold) begin
            if (!ab) m_hold = 0;
        end else if (ab && m_prev_ab && m_dprev > 0 && d <= 0) begin
            fr = (16 * m_dprev) / (m_dprev - d);
            if (fr > 15) fr = 15;
            ip = 16'(idx - 13);
            e.due = idx;
            e.ts  = {ip, 4'(fr)};
            e.pk  = m_prev;
            e.tag = cur_tag;
            sb_q.push_back(e);
            m_hold = 1;
        end
        m_prev = s;
        m_dprev = d;
        m_prev_ab = ab;
        idx++;
        @(negedge clk);
    endtask

    task automatic drive_list(input int vals[]);
        foreach (vals[i]) drive(vals[i]);
    endtask

    // Monitor: samples one ns after each rising edge.
    initial begin
        wait (run_mon);
        forever begin
            @(posedge clk);
            #1;
            if (time_valid) begin
                if (sb_q.size() == 0) begin
                    chk(0, "R2", "unexpected strobe stamp", time_stamp, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(e.due == idx - 1, "R4", "strobe index", idx - 1, e.due);
                    chk(time_stamp == e.ts, e.tag, "time_stamp", time_stamp, e.ts);
                    chk(peak_amp == e.pk, "R5", "peak_amp", peak_amp, e.pk);
                end
                last_ts = time_stamp;
                last_pk = peak_amp;
            end else begin
                chk(time_stamp == last_ts && peak_amp == last_pk, "R10",
                    "held stamp", time_stamp, last_ts);
                if (sb_q.size() != 0 && sb_q[0].due < idx - 1) begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(0, e.tag, "missing strobe for index", idx - 1, e.due);
                end
            end
        end
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R4 watchdog: actual=hung expected=finished");
            report();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        chk(time_valid == 0, "R1", "valid in reset", time_valid, 0);
        chk(time_stamp == 0, "R1", "stamp in reset", time_stamp, 0);
        chk(peak_amp == 0, "R1", "peak in reset", peak_amp, 0);
        @(negedge clk);
        rst_n = 1'b1;
        run_mon = 1;

        // R7: top at index 1, integer part wraps to 65524, fraction 12
        cur_tag = "R7";
        drive_list('{300, 200, 0, 0});
        chk(sb_q.size() == 0, "R7", "wrap result pending", sb_q.size(), 0);
        drive_list('{0, 0, 0});

        // R3 / R6: ordinary pulse, fraction 16*100/150 = 10
        cur_tag = "R6";
        drive_list('{20, 50, 150, 300, 400, 350, 200, 80, 0, 0});

        // R2: isolated spike and a plateau exactly at the level
        cur_tag = "R2";
        drive_list('{0, 500, 0, 0, 100, 100, 100, 0, 0});

        // R8: qualified rise that collapses before any top, then a fresh pulse
        cur_tag = "R8";
        drive_list('{0, 200, 300, 50, 400, 350, 0, 0});
        drive_list('{0, 200, 300, 350, 250, 0, 0});

        // R6: flat step counts as the top, fraction saturates at 15
        cur_tag = "R6";
        drive_list('{0, 200, 300, 300, 200, 0, 0});

        // R9: double hump above the level gives one result only
        cur_tag = "R9";
        drive_list('{0, 200, 400, 300, 350, 500, 300, 50, 0});
        drive_list('{0, 200, 600, 300, 0, 0});

        // R11: top on the qualifying sample, fraction 16*400/500 = 12
        cur_tag = "R11";
        drive_list('{0, 400, 300, 0, 0});

        // R3: randomised triangular pulses with varying levels
        cur_tag = "R3";
        for (int p = 0; p < 40; p++) begin
            int amp;
            int rl;
            int fl;
            threshold = 10'($urandom_range(40, 140));
            amp = $urandom_range(180, 1000);
            rl  = $urandom_range(1, 5);
            fl  = $urandom_range(1, 6);
            for (int k = 0; k < 3; k++) drive($urandom_range(0, 30));
            for (int k = 1; k <= rl; k++) drive((amp * k) / rl - $urandom_range(0, 5));
            if ($urandom_range(0, 2) == 0) drive(amp);
            for (int k = fl - 1; k >= 0; k--) drive((amp * k) / fl);
            for (int k = 0; k < 2; k++) drive($urandom_range(0, 30));
        end

        threshold = 10'd100;
        for (int k = 0; k < 6; k++) drive(0);
        chk(sb_q.size() == 0, "R4", "results left unseen", sb_q.size(), 0);
        done = 1;
        report();
    end

endmodule